// File: doc/BRIEF.md
# Legacy Interrupt Message Generator

This block turns level-sensitive legacy interrupt requests from up to eight PCI Express functions into a stream of assert and deassert interrupt message requests. Each function carries a small pin-select setting that steers its request onto one of four virtual interrupt wires (A, B, C, D), or onto none. A per-function disable bit can mask a request before it reaches its wire. The routed requests are ORed per wire, and each change in a wire's combined level becomes one message request for that wire.

Message requests leave through a valid/ready handshake that carries an 8-bit message code. Every wire keeps its own record of the last level it announced. A wire is pending while its current level differs from that record. If the level returns to the announced value before the message is taken, the pending request disappears, so asserts and deasserts always alternate on each wire. A registered copy of the raw request vector is provided for the functions' status register interrupt bits. The block does not build packets and does not store configuration space.

Top module: `intx_msg_gen`

## Requirements
- R1: `sts_o[i]` equals `int_req_i[i]` as sampled at the previous clock edge, whatever the function's pin setting and disable bit.
- R2: Function i uses pin field `pin_cfg_i[3*i+2:3*i]`. Values 1, 2, 3 and 4 route its request to wire A, B, C and D (wire index 0 to 3). Values 0 and 5 to 7 route it nowhere, so it produces no message.
- R3: When `int_dis_i[i]` is 1, function i's request does not contribute to any wire.
- R4: A wire's level is the OR of all enabled requests routed to it. When the level rises, the block requests code 0x20+w. When it falls, the block requests code 0x24+w, where w is the wire index.
- R5: `msg_valid_o` is low whenever every wire's registered level equals its last accepted level. A level change that does not alter the OR result produces no message.
- R6: When several wires are pending, the lowest wire index is offered first, and only one message is offered at a time.
- R7: While `msg_valid_o` is high and `msg_ready_i` is low, and no input changes, `msg_valid_o` and `msg_code_o` hold steady.
- R8: If a wire's level returns to its last accepted value before its message is accepted, that message is withdrawn. No wire ever has two accepted asserts, or two accepted deasserts, in a row.
- R9: After reset, `msg_valid_o` and `sts_o` are 0 and every wire counts as deasserted.
- R10: A request change applied before clock edge t shows up on `msg_valid_o`/`msg_code_o` after edge t. A message is consumed at the edge where valid and ready are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| int_req_i | input | NFUNC | Level interrupt request, one bit per function |
| int_dis_i | input | NFUNC | Per-function interrupt disable |
| pin_cfg_i | input | 3*NFUNC | Per-function pin select, 3 bits each |
| msg_ready_i | input | 1 | Consumer accepts the offered message |
| msg_valid_o | output | 1 | A message request is offered |
| msg_code_o | output | 8 | Message code of the offered request |
| sts_o | output | NFUNC | Per-function pending interrupt status bits |

## Verification
The assertions check on every cycle that the status vector tracks the request of the previous cycle and that the offered code is always one of the eight legal values. They also check that the lowest pending wire wins, that an offer holds while stalled on steady inputs, and that a wire is accepted only while it differs from its announced level. What only the bench's scenarios can show is that the full message sequence is correct: the right wire and polarity for each routing, masking and OR-sharing pattern, the withdrawal of a message that toggles back, and the drain order across several wires. The bench covers these with a reference model fed by swept and pseudo-random configurations.

// File: rtl/intx_pkg.sv
// Shared constants for the legacy interrupt message generator.
// Assumes exactly four virtual wires and 3-bit pin select fields.
package intx_pkg;
    localparam int NWIRE = 4;
    localparam int PIN_W = 3;
    localparam int CODE_W = 8;
    localparam logic [CODE_W-1:0] CODE_ASSERT_BASE   = 8'h20;
    localparam logic [CODE_W-1:0] CODE_DEASSERT_BASE = 8'h24;
endpackage

// File: rtl/intx_router.sv
// Steers each function's request onto its selected virtual wire and ORs per wire.
// Assumes pin select 1..NWIRE picks wire 0..NWIRE-1; every other value routes nowhere.
module intx_router
    import intx_pkg::*;
#(
    parameter int NFUNC = 8
) (
    input  logic [NFUNC-1:0]       req_i,
    input  logic [NFUNC-1:0]       dis_i,
    input  logic [NFUNC*PIN_W-1:0] pin_i,
    output logic [NWIRE-1:0]       lvl_o
);
    for (genvar w = 0; w < NWIRE; w++) begin : g_wire
        logic [NFUNC-1:0] hit;
        for (genvar f = 0; f < NFUNC; f++) begin : g_func
            // One function's enabled contribution to this wire.
            assign hit[f] = req_i[f] && !dis_i[f] &&
                            (pin_i[f*PIN_W +: PIN_W] == PIN_W'(w + 1));
        end
        // Combine all contributions to the wire.
        assign lvl_o[w] = |hit;
    end
endmodule

// File: rtl/intx_wire_tracker.sv
// Holds one wire's registered level and the last level that was announced.
// Pending means the two differ. Accepting a message copies the level into the announced record.
module intx_wire_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_d,
    input  logic accept_i,
    output logic lvl_q,
    output logic pend_o
);
    logic sent_q;

    // Register the combined wire level.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl_d;
    end

    // Update the announced level when the message is consumed.
    always_ff @(posedge clk) begin
        if (!rst_n)        sent_q <= 1'b0;
        else if (accept_i) sent_q <= lvl_q;
    end

    assign pend_o = lvl_q ^ sent_q;

    AST_ACCEPT_ONLY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        accept_i |-> (lvl_q != sent_q)); // R8
    AST_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_i && (lvl_d == lvl_q)) |=> !pend_o); // R4
endmodule

// File: rtl/intx_arbiter.sv
// Fixed-priority selection among pending wires (lowest index wins) and code formation.
// Assumes pending flags and levels come from registered per-wire trackers.
module intx_arbiter
    import intx_pkg::*;
(
    input  logic [NWIRE-1:0]  pend_i,
    input  logic [NWIRE-1:0]  lvl_i,
    input  logic              ready_i,
    output logic              valid_o,
    output logic [CODE_W-1:0] code_o,
    output logic [NWIRE-1:0]  accept_o
);
    logic [NWIRE-1:0] grant;

    // Pick the lowest pending wire and build its code.
    always_comb begin
        grant  = '0;
        code_o = '0;
        for (int w = NWIRE - 1; w >= 0; w--) begin
            if (pend_i[w]) begin
                grant  = '0;
                grant[w] = 1'b1;
                code_o = (lvl_i[w] ? CODE_ASSERT_BASE : CODE_DEASSERT_BASE) + CODE_W'(w);
            end
        end
    end

    assign valid_o  = |pend_i;
    assign accept_o = grant & {NWIRE{ready_i}};

    always_comb begin
        AST_GRANT_ONEHOT: assert ($onehot0(grant)); // R6
        AST_PRIO_WIRE_A: assert (!(pend_i[0] && !grant[0])); // R6
    end
endmodule

// File: rtl/intx_msg_gen.sv
// Top: routes per-function legacy interrupt requests to four wires and tracks each wire's level.
// Offers assert/deassert messages through a valid/ready handshake and exports registered status bits.
// Assumes the consumer may hold ready high continuously; messages are offered in wire A-first order.
module intx_msg_gen
    import intx_pkg::*;
#(
    parameter int NFUNC = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NFUNC-1:0]       int_req_i,
    input  logic [NFUNC-1:0]       int_dis_i,
    input  logic [NFUNC*PIN_W-1:0] pin_cfg_i,
    input  logic                   msg_ready_i,
    output logic                   msg_valid_o,
    output logic [CODE_W-1:0]      msg_code_o,
    output logic [NFUNC-1:0]       sts_o
);
    logic [NWIRE-1:0] lvl_d, lvl_q, pend, accept;

    intx_router #(.NFUNC(NFUNC)) i_router (
        .req_i (int_req_i),
        .dis_i (int_dis_i),
        .pin_i (pin_cfg_i),
        .lvl_o (lvl_d)
    );

    for (genvar w = 0; w < NWIRE; w++) begin : g_trk
        intx_wire_tracker i_trk (
            .clk      (clk),
            .rst_n    (rst_n),
            .lvl_d    (lvl_d[w]),
            .accept_i (accept[w]),
            .lvl_q    (lvl_q[w]),
            .pend_o   (pend[w])
        );
    end

    intx_arbiter i_arb (
        .pend_i   (pend),
        .lvl_i    (lvl_q),
        .ready_i  (msg_ready_i),
        .valid_o  (msg_valid_o),
        .code_o   (msg_code_o),
        .accept_o (accept)
    );

    // Record the raw request of each function for its status bit.
    always_ff @(posedge clk) begin
        if (!rst_n) sts_o <= '0;
        else        sts_o <= int_req_i;
    end

    AST_STS_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        sts_o == $past(int_req_i)); // R1
    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid_o |-> (msg_code_o >= 8'h20 && msg_code_o <= 8'h27)); // R4
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid_o && !msg_ready_i && (lvl_d == lvl_q)) |=>
            (msg_valid_o && $stable(msg_code_o))); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |-> !msg_valid_o); // R5
endmodule

// File: tb/test_intx_msg_gen.sv
module test_intx_msg_gen;
    localparam int NF = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NF-1:0] req = '0, dis = '0;
    logic [NF*3-1:0] pin = '0;
    logic          rdy = 1'b0;
    logic          vld;
    logic [7:0]    code;
    logic [NF-1:0] sts;

    int checks = 0, fails = 0;
    logic [3:0] exp_sent = '0;
    bit done = 0;

    always #5 clk = ~clk;

    intx_msg_gen #(.NFUNC(NF)) i_intx_msg_gen (
        .clk(clk), .rst_n(rst_n), .int_req_i(req), .int_dis_i(dis),
        .pin_cfg_i(pin), .msg_ready_i(rdy), .msg_valid_o(vld),
        .msg_code_o(code), .sts_o(sts)
    );

    task automatic chk(input string r, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", r, act, exp);
        end
    endtask

    // Reference wire levels computed from the requirements (R2, R3, R4).
    function automatic logic [3:0] model_lvl();
        logic [3:0] l = '0;
        for (int f = 0; f < NF; f++) begin
            int p = int'(pin[f*3 +: 3]);
            if (req[f] && !dis[f] && p >= 1 && p <= 4) l[p-1] = 1'b1;
        end
        return l;
    endfunction

    // Expected offer: lowest wire whose level differs from the announced level (R6).
    task automatic check_offer(input string r);
        logic [3:0] l = model_lvl();
        logic [3:0] d = l ^ exp_sent;
        int ec = 0;
        for (int w = 3; w >= 0; w--)
            if (d[w]) ec = (l[w] ? 32'h20 : 32'h24) + w;
        chk({r, " valid R5"}, int'(vld), int'(d != 0));
        if (d != 0) chk({r, " code R4 R6"}, int'(code), ec);
    endtask

    // Apply inputs at negedge; outputs settle after the next edge (R10).
    task automatic apply(input logic [NF-1:0] rq, input logic [NF-1:0] ds, input logic [NF*3-1:0] pn);
        req = rq; dis = ds; pin = pn;
        @(posedge clk); @(negedge clk);
        chk("R1 status", int'(sts), int'(rq));
    endtask

    // Consume every offered message, checking each one against the model.
    task automatic drain(input string r);
        for (int k = 0; k < 6; k++) begin
            check_offer(r);
            if (!vld) break;
            rdy = 1'b1;
            @(posedge clk);
            for (int w = 0; w < 4; w++)
                if ((model_lvl() ^ exp_sent) != 0 && (((model_lvl() ^ exp_sent) & ((4'b1 << w) - 4'b1)) == 0)
                    && (model_lvl()[w] != exp_sent[w])) begin
                    exp_sent[w] = model_lvl()[w];
                    break;
                end
            @(negedge clk);
            rdy = 1'b0;
        end
        chk({r, " idle R5"}, int'(vld), 0);
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog R10 act=1 exp=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr = 32'h1ACE_B00C;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk("R9 valid", int'(vld), 0);
        chk("R9 status", int'(sts), 0);

        // R2 R3: sweep every function, pin value and disable bit.
        for (int f = 0; f < NF; f++)
            for (int p = 0; p < 8; p++)
                for (int d = 0; d < 2; d++) begin
                    logic [NF*3-1:0] pn = '0;
                    pn[f*3 +: 3] = 3'(p);
                    apply(NF'(1) << f, NF'(d) << f, pn);
                    drain("R2 R3 raise");
                    apply('0, NF'(d) << f, pn);
                    drain("R2 R3 lower");
                end

        // R4: two functions sharing wire B; only the outer edges create messages.
        apply(8'h01, '0, {18'd0, 3'd2, 3'd2});
        drain("R4 first");
        apply(8'h03, '0, {18'd0, 3'd2, 3'd2});
        chk("R4 shared no msg", int'(vld), 0);
        apply(8'h02, '0, {18'd0, 3'd2, 3'd2});
        chk("R4 partial drop no msg", int'(vld), 0);
        apply(8'h00, '0, {18'd0, 3'd2, 3'd2});
        chk("R4 deassert B", int'(code), 32'h25);
        drain("R4 last");

        // R7 R8: stall, then withdraw by toggling back.
        apply(8'h04, '0, {15'd0, 3'd3, 6'd0});
        chk("R7 offer C", int'(code), 32'h22);
        @(posedge clk); @(negedge clk);
        chk("R7 hold valid", int'(vld), 1);
        chk("R7 hold code", int'(code), 32'h22);
        apply(8'h00, '0, {15'd0, 3'd3, 6'd0});
        chk("R8 withdrawn", int'(vld), 0);

        // R6: all four wires at once drain A, B, C, D in order.
        apply(8'h0F, '0, {12'd0, 3'd4, 3'd3, 3'd2, 3'd1});
        chk("R6 first A", int'(code), 32'h20);
        drain("R6 order");

        // R10 and mixed patterns from a pseudo-random sequence.
        for (int it = 0; it < 300; it++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            apply(lfsr[7:0], lfsr[15:8] & lfsr[23:16], {lfsr[31:16], lfsr[7:0]} ^ 24'h5A3C96);
            if (it % 3 != 0) drain("R10 random");
            else check_offer("R10 random pending");
        end
        apply('0, '0, '0);
        drain("R10 final");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule